// File: doc/BRIEF.md
# Write Command and Data Pairing Front End

This block is the user-side write entry stage of a DRAM controller. A requester hands it write commands (address plus operation code) on one handshake channel and write data (a full burst beat, a byte mask and an end-of-burst marker) on a second, independent handshake channel. Each channel fills its own FIFO. The block joins the oldest queued command with the oldest queued data beat and presents the pair on a backend port with valid/ready handshaking.

The two channels are not in lockstep. Data can be loaded any number of cycles before its command, limited only by the depth of the data FIFO. Data can also arrive in the same cycle as its command or up to two cycles after it. Data arriving later than that breaks the protocol and sets a sticky error flag. Every beat must carry the end-of-burst marker, because at the 4:1 clock ratio a single beat carries a whole burst of eight. A beat without the marker sets a second sticky flag.

Top module: `wrPairFront`

## Requirements
- R1: A command is taken only on a rising edge where `cmdEn` and `cmdRdy` are both high. A command held while `cmdRdy` is low is taken once, on the first edge after `cmdRdy` returns high.
- R2: A data beat is taken only on a rising edge where `wdEn` and `wdRdy` are both high.
- R3: `cmdRdy` is low while the command FIFO holds `CMD_DEPTH` entries (default 4), and high otherwise outside reset.
- R4: `wdRdy` is low while the data FIFO holds `DATA_DEPTH` entries (default 8), and high otherwise outside reset.
- R5: The n-th command taken since reset is output together with the n-th data beat taken since reset.
- R6: Data may be taken any number of cycles before its command. A command taken after several queued beats pairs with the oldest of them.
- R7: `outValid` is high exactly when both FIFOs hold at least one entry. A command and a beat taken on the same edge give `outValid` high from that edge on.
- R8: While `outValid` is high and `outRdy` is low, the output fields hold steady. A pair is removed on each edge where both `outValid` and `outRdy` are high.
- R9: Let a command be taken in cycle c. If, by the end of cycle c+2, fewer beats have been taken than commands taken up to and including cycle c, `lateErr` rises at the edge that ends cycle c+2. Data taken in cycle c+1 or c+2 does not set it.
- R10: `lateErr` and `endErr` stay high until reset.
- R11: A beat taken with `wdEnd` low sets `endErr` from the next edge. The beat is still queued and paired.
- R12: A synchronous active-high `rst` empties both FIFOs and clears both flags. `cmdRdy` and `wdRdy` are low while `rst` is high and for one further cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdEn | input | 1 | Command request |
| cmdAddr | input | ADDR_W | Command address |
| cmdOp | input | OP_W | Command operation code |
| cmdRdy | output | 1 | Command FIFO can take a command |
| wdEn | input | 1 | Write data request |
| wdData | input | DATA_W | Write data beat |
| wdMask | input | DATA_W/8 | Byte mask for the beat |
| wdEnd | input | 1 | End-of-burst marker |
| wdRdy | output | 1 | Data FIFO can take a beat |
| outValid | output | 1 | A command/data pair is presented |
| outAddr | output | ADDR_W | Address of the presented pair |
| outOp | output | OP_W | Operation code of the presented pair |
| outData | output | DATA_W | Data of the presented pair |
| outMask | output | DATA_W/8 | Byte mask of the presented pair |
| outRdy | input | 1 | Backend takes the presented pair |
| lateErr | output | 1 | Sticky flag: data trailed a command by more than two cycles |
| endErr | output | 1 | Sticky flag: a beat arrived without the end marker |

## Verification
Each accepted command or beat becomes visible one edge after it is taken. That edge updates the FIFO occupancy that drives `cmdRdy`, `wdRdy` and `outValid`, and it also updates `endErr`. `lateErr` belongs to the edge that closes the third cycle counted from the command's cycle. The bench holds a queue-based model that advances on the same rising edge the design uses. It compares every output at the following falling edge, once all registers have settled and before the next stimulus is driven. The directed checks use the same rule, so the late-data case checks the flag at the second falling edge after the command edge (clear) and again at the third (set).

// File: rtl/wrPairPkg.sv
package wrPairPkg;
  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic cmdPush;
    logic dataPush;
    logic pairPop;
  } pairStb_t;
endpackage

// File: rtl/wrPairFifo.sv
module wrPairFifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      unique case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rdPtr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  // R3 R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
  // R3 R4
  count_range_chk: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH));
endmodule

// File: rtl/wrPairPath.sv
module wrPairPath import wrPairPkg::*; #(
  parameter int ADDR_W     = 28,
  parameter int OP_W       = 3,
  parameter int DATA_W     = 64,
  parameter int CMD_DEPTH  = 4,
  parameter int DATA_DEPTH = 8,
  localparam int MASK_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pairStb_t          stb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [OP_W-1:0]   cmdOp,
  input  logic [DATA_W-1:0] wdData,
  input  logic [MASK_W-1:0] wdMask,
  output logic [ADDR_W-1:0] headAddr,
  output logic [OP_W-1:0]   headOp,
  output logic [DATA_W-1:0] headData,
  output logic [MASK_W-1:0] headMask,
  output logic              cmdFull,
  output logic              cmdEmpty,
  output logic              dataFull,
  output logic              dataEmpty
);
  localparam int CMD_W = ADDR_W + OP_W;
  localparam int DAT_W = DATA_W + MASK_W;

  logic [CMD_W-1:0] cmdHead;
  logic [DAT_W-1:0] datHead;

  wrPairFifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) cmdQ (
    .clk(clk), .rst(rst), .push(stb.cmdPush), .din({cmdAddr, cmdOp}),
    .pop(stb.pairPop), .dout(cmdHead), .full(cmdFull), .empty(cmdEmpty)
  );

  wrPairFifo #(.W(DAT_W), .DEPTH(DATA_DEPTH)) datQ (
    .clk(clk), .rst(rst), .push(stb.dataPush), .din({wdMask, wdData}),
    .pop(stb.pairPop), .dout(datHead), .full(dataFull), .empty(dataEmpty)
  );

  assign {headAddr, headOp}  = cmdHead;
  assign {headMask, headData} = datHead;

  // R8
  pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmdEmpty && !dataEmpty && !stb.pairPop) |=>
      ($stable(headAddr) && $stable(headOp) && $stable(headData) && $stable(headMask)));
endmodule

// File: rtl/wrPairCtrl.sv
module wrPairCtrl import wrPairPkg::*; #(
  parameter int CMD_DEPTH  = 4,
  parameter int DATA_DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cmdEn,
  input  logic     wdEn,
  input  logic     wdEnd,
  input  logic     outRdy,
  input  logic     cmdFull,
  input  logic     cmdEmpty,
  input  logic     dataFull,
  input  logic     dataEmpty,
  output pairStb_t stb,
  output logic     cmdRdy,
  output logic     wdRdy,
  output logic     outValid,
  output logic     lateErr,
  output logic     endErr
);
  // Signed balance: commands older than two cycles minus beats taken
  localparam int OW = $clog2(CMD_DEPTH + DATA_DEPTH + 4) + 2;

  logic                 rstHold;
  logic [1:0]           cmdHist;
  logic signed [OW-1:0] owe, oweNext;
  logic                 cmdAcc, datAcc;

  assign cmdRdy   = !rst && !rstHold && !cmdFull;
  assign wdRdy    = !rst && !rstHold && !dataFull;
  assign cmdAcc   = cmdEn && cmdRdy;
  assign datAcc   = wdEn && wdRdy;
  assign outValid = !cmdEmpty && !dataEmpty;

  always_comb begin
    stb         = '0;
    stb.cmdPush = cmdAcc;
    stb.dataPush = datAcc;
    stb.pairPop = outValid && outRdy;
  end

  assign oweNext = owe + $signed({{(OW-1){1'b0}}, cmdHist[1]})
                       - $signed({{(OW-1){1'b0}}, datAcc});

  always_ff @(posedge clk) begin
    if (rst) begin
      rstHold <= 1'b1;
      cmdHist <= '0;
      owe     <= '0;
      lateErr <= 1'b0;
      endErr  <= 1'b0;
    end else begin
      rstHold <= 1'b0;
      cmdHist <= {cmdHist[0], cmdAcc};
      owe     <= oweNext;
      if (oweNext > 0)         lateErr <= 1'b1;
      if (datAcc && !wdEnd)    endErr  <= 1'b1;
    end
  end

  // R12
  rdy_after_reset_chk: assert property (@(posedge clk) $fell(rst) |-> (!cmdRdy && !wdRdy));
  // R10
  late_sticky_chk: assert property (@(posedge clk) disable iff (rst) lateErr |=> lateErr);
  // R10
  end_sticky_chk: assert property (@(posedge clk) disable iff (rst) endErr |=> endErr);
  // R11
  end_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(endErr) |-> $past(wdEn && wdRdy && !wdEnd));
endmodule

// File: rtl/wrPairFront.sv
module wrPairFront import wrPairPkg::*; #(
  parameter int ADDR_W     = 28,
  parameter int OP_W       = 3,
  parameter int DATA_W     = 64,
  parameter int CMD_DEPTH  = 4,
  parameter int DATA_DEPTH = 8,
  localparam int MASK_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdEn,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [OP_W-1:0]   cmdOp,
  output logic              cmdRdy,
  input  logic              wdEn,
  input  logic [DATA_W-1:0] wdData,
  input  logic [MASK_W-1:0] wdMask,
  input  logic              wdEnd,
  output logic              wdRdy,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [OP_W-1:0]   outOp,
  output logic [DATA_W-1:0] outData,
  output logic [MASK_W-1:0] outMask,
  input  logic              outRdy,
  output logic              lateErr,
  output logic              endErr
);
  pairStb_t stb;
  logic cmdFull, cmdEmpty, dataFull, dataEmpty;

  wrPairCtrl #(.CMD_DEPTH(CMD_DEPTH), .DATA_DEPTH(DATA_DEPTH)) ctrl (
    .clk(clk), .rst(rst), .cmdEn(cmdEn), .wdEn(wdEn), .wdEnd(wdEnd),
    .outRdy(outRdy), .cmdFull(cmdFull), .cmdEmpty(cmdEmpty),
    .dataFull(dataFull), .dataEmpty(dataEmpty), .stb(stb),
    .cmdRdy(cmdRdy), .wdRdy(wdRdy), .outValid(outValid),
    .lateErr(lateErr), .endErr(endErr)
  );

  wrPairPath #(.ADDR_W(ADDR_W), .OP_W(OP_W), .DATA_W(DATA_W),
               .CMD_DEPTH(CMD_DEPTH), .DATA_DEPTH(DATA_DEPTH)) path (
    .clk(clk), .rst(rst), .stb(stb), .cmdAddr(cmdAddr), .cmdOp(cmdOp),
    .wdData(wdData), .wdMask(wdMask), .headAddr(outAddr), .headOp(outOp),
    .headData(outData), .headMask(outMask), .cmdFull(cmdFull),
    .cmdEmpty(cmdEmpty), .dataFull(dataFull), .dataEmpty(dataEmpty)
  );
endmodule

// File: tb/wrPairFront_test.sv
module wrPairFront_test;
  localparam int AW = 28, OW = 3, DW = 64, MW = DW / 8, CD = 4, DD = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdEn = 1'b0, wdEn = 1'b0, wdEnd = 1'b1, outRdy = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic [OW-1:0] cmdOp = '0;
  logic [DW-1:0] wdData = '0;
  logic [MW-1:0] wdMask = '0;
  logic cmdRdy, wdRdy, outValid, lateErr, endErr;
  logic [AW-1:0] outAddr;
  logic [OW-1:0] outOp;
  logic [DW-1:0] outData;
  logic [MW-1:0] outMask;

  int nChecks = 0, nErrs = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wrPairFront uut (
    .clk(clk), .rst(rst), .cmdEn(cmdEn), .cmdAddr(cmdAddr), .cmdOp(cmdOp),
    .cmdRdy(cmdRdy), .wdEn(wdEn), .wdData(wdData), .wdMask(wdMask),
    .wdEnd(wdEnd), .wdRdy(wdRdy), .outValid(outValid), .outAddr(outAddr),
    .outOp(outOp), .outData(outData), .outMask(outMask), .outRdy(outRdy),
    .lateErr(lateErr), .endErr(endErr)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [AW+OW-1:0] mCmd[$];
  logic [MW+DW-1:0] mDat[$];
  int mCmdT[$];
  int mCyc = 0, mDataTot = 0, oldN;
  bit mLate = 0, mEnd = 0, mHold = 1, cr, dr, pp;

  always @(posedge clk) begin
    if (rst) begin
      mCmd.delete(); mDat.delete(); mCmdT.delete();
      mDataTot = 0; mLate = 0; mEnd = 0; mHold = 1;
    end else begin
      cr = !mHold && mCmd.size() < CD;
      dr = !mHold && mDat.size() < DD;
      pp = mCmd.size() > 0 && mDat.size() > 0 && outRdy;
      if (pp) begin
        void'(mCmd.pop_front());
        void'(mDat.pop_front());
      end
      if (cmdEn && cr) begin
        mCmd.push_back({cmdAddr, cmdOp});
        mCmdT.push_back(mCyc);
      end
      if (wdEn && dr) begin
        mDat.push_back({wdMask, wdData});
        mDataTot++;
        if (!wdEnd) mEnd = 1;
      end
      oldN = 0;
      foreach (mCmdT[i]) if (mCmdT[i] <= mCyc - 2) oldN++;
      if (oldN > mDataTot) mLate = 1;
      mHold = 0;
    end
    mCyc++;
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R3 R12", cmdRdy, !rst && !mHold && mCmd.size() < CD);
      chk("R4 R12", wdRdy, !rst && !mHold && mDat.size() < DD);
      chk("R7", outValid, mCmd.size() > 0 && mDat.size() > 0);
      if (mCmd.size() > 0 && mDat.size() > 0) begin
        chk("R1 R5 R8", {outAddr, outOp}, mCmd[0]);
        chk("R2 R5 R6", {outMask, outData}, mDat[0]);
      end
      chk("R9 R10", lateErr, mLate);
      chk("R11 R10", endErr, mEnd);
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    cmdEn = 1'b0;
    wdEn  = 1'b0;
    wdEnd = 1'b1;
  endtask

  task automatic doReset();
    idle();
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
  endtask

  task automatic putCmd(input int a);
    cmdEn = 1'b1; cmdAddr = AW'(a); cmdOp = OW'(a);
  endtask

  task automatic putDat(input int d);
    wdEn = 1'b1; wdData = DW'(d); wdMask = MW'(d * 3); wdEnd = 1'b1;
  endtask

  initial begin
    int acc, dacc;
    logic [AW-1:0] heldAddr;
    // Reset behaviour
    repeat (3) tick();
    chk("R12", {cmdRdy, wdRdy}, 2'b00);
    rst = 1'b0;
    #1;
    chk("R12 ready low one cycle after reset", {cmdRdy, wdRdy}, 2'b00);
    tick();
    chk("R12 ready back", {cmdRdy, wdRdy, outValid}, 3'b110);

    // Data well ahead of commands (R6, R5, R8)
    outRdy = 1'b0;
    for (int i = 0; i < 5; i++) begin putDat(32'hA0 + i); tick(); end
    idle();
    for (int i = 0; i < 3; i++) begin putCmd(100 + i); tick(); end
    idle();
    tick();
    chk("R6 first command meets oldest beat", {outAddr, outData}, {AW'(100), DW'(32'hA0)});
    heldAddr = outAddr;
    repeat (3) tick();
    chk("R8 held while backend stalls", {outValid, outAddr}, {1'b1, heldAddr});
    outRdy = 1'b1;
    tick();
    outRdy = 1'b0;
    #1;
    chk("R5 second pair", {outAddr, outData}, {AW'(101), DW'(32'hA1)});
    outRdy = 1'b1;
    repeat (3) tick();
    chk("R7 no pair with data only", outValid, 1'b0);

    // Same-edge command and data (R7)
    doReset();
    tick();
    outRdy = 1'b0;
    putCmd(300);
    tick();
    idle();
    chk("R7 command alone gives no pair", outValid, 1'b0);
    putDat(32'hB0);
    putCmd(301);
    tick();
    idle();
    chk("R7 pair after data", {outValid, outAddr, outData}, {1'b1, AW'(300), DW'(32'hB0)});
    outRdy = 1'b1;
    repeat (3) tick();

    // Data trailing by one and two cycles (R9)
    doReset();
    tick();
    putCmd(400); tick(); idle(); tick(); putDat(32'hC0); tick(); idle();
    putCmd(401); tick(); idle(); putDat(32'hC1); tick(); idle();
    repeat (3) tick();
    chk("R9 two-cycle lag allowed", lateErr, 1'b0);

    // Fill both FIFOs (R3, R4, R1)
    doReset();
    tick();
    outRdy = 1'b0;
    acc = 0; dacc = 0;
    for (int i = 0; i < 10; i++) begin
      putCmd(500 + acc);
      putDat(32'hD0 + dacc);
      tick();
      if (mCmd.size() > acc) acc++;
      if (mDat.size() > dacc) dacc++;
    end
    chk("R3 command FIFO full", {cmdRdy, 32'(acc)}, {1'b0, 32'(CD)});
    chk("R4 data FIFO full", {wdRdy, 32'(dacc)}, {1'b0, 32'(DD)});
    wdEn = 1'b0;
    outRdy = 1'b1;
    tick();
    outRdy = 1'b0;
    tick();
    chk("R1 held command taken once ready returns", mCmd.size(), 32'(CD));
    idle();
    outRdy = 1'b1;
    repeat (8) tick();

    // Missing end marker (R11)
    doReset();
    tick();
    outRdy = 1'b0;
    putDat(32'hE0); wdEnd = 1'b0; putCmd(600);
    tick();
    idle();
    chk("R11 flag and beat queued", {endErr, outValid, outData}, {1'b1, 1'b1, DW'(32'hE0)});
    outRdy = 1'b1;
    repeat (2) tick();

    // Late data (R9, R10, R12)
    doReset();
    tick();
    putCmd(700); tick(); idle();
    tick();
    chk("R9 not late yet", lateErr, 1'b0);
    tick();
    chk("R9 late flagged", lateErr, 1'b1);
    putDat(32'hF0); tick(); idle();
    repeat (4) tick();
    chk("R10 flag sticky", lateErr, 1'b1);
    doReset();
    #1;
    chk("R12 flags cleared", {lateErr, endErr, outValid}, 3'b000);

    // Mixed random traffic with protocol-correct holding
    tick();
    for (int i = 0; i < 3000; i++) begin
      if (!(cmdEn && !cmdRdy)) begin
        if ($urandom_range(0, 2) == 0) putCmd(int'($urandom_range(0, 32'h0FFFFFFF)));
        else cmdEn = 1'b0;
      end
      if (!(wdEn && !wdRdy)) begin
        if ($urandom_range(0, 1) == 0) begin
          putDat(int'($urandom));
          wdEnd = ($urandom_range(0, 40) != 0);
        end else wdEn = 1'b0;
      end
      outRdy = ($urandom_range(0, 3) != 0);
      tick();
    end
    idle();
    repeat (4) tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end

  initial begin
    #(8 * 100000);
    nErrs++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end
endmodule